// File: doc/BRIEF.md
# Predicated Vector Arithmetic Right Shifter

This block shifts the lanes of a fixed-length vector right by an immediate amount, copying the sign bit into the vacated high bits. It writes the result back in place. A per-byte predicate mask decides which lanes are shifted. Lanes that are not selected keep their original bits, so the predicate merges rather than zeroes.

The caller does not supply the lane width and the shift count separately. It passes two raw immediate fields: a 4-bit size field and a 3-bit low field. The block decodes both quantities from their concatenation. A size field of zero is reserved and is reported as illegal.

A request is accepted with `in_valid`. The result, the illegal flag and `out_valid` appear one clock later. The vector length is a parameter, 256 bits by default.

Top module: `vec_sra_unit`

## Requirements
- R1: The lane width is 8 shifted left by the index of the highest set bit of `in_size`. So `0001` selects 8-bit lanes, `001x` selects 16, `01xx` selects 32 and `1xxx` selects 64.
- R2: The shift count is twice the lane width minus the unsigned 7-bit value `{in_size, in_imm3}`. For every legal encoding this count lies between 1 and the lane width, inclusive.
- R3: A shift count equal to the lane width fills every bit of an active lane with that lane's sign bit.
- R4: An active lane is shifted right arithmetically. Result bit b takes operand bit b+count when that bit is inside the lane, and the lane's top bit otherwise.
- R5: A lane whose predicate is inactive appears in `out_vec` with its operand bits unchanged.
- R6: Lane i is active when `in_pred[i*W/8]` is 1, where W is the lane width. The predicate bits at the lane's higher byte positions have no effect.
- R7: When `in_size` is `0000`, `out_illegal` is 1 and `out_vec` equals `in_vec` unchanged. For any other size value, `out_illegal` is 0.
- R8: `out_vec`, `out_illegal` and `out_valid` are registered. They reflect the request one clock edge after `in_valid` was sampled high. Reset clears `out_valid`.
- R9: After an edge at which `in_valid` was low, `out_valid` is 0, and `out_vec` and `out_illegal` hold their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request strobe |
| in_vec | input | VLEN | Source vector operand |
| in_pred | input | VLEN/8 | Predicate, one bit per byte |
| in_size | input | 4 | Size field of the immediate |
| in_imm3 | input | 3 | Low three bits of the immediate |
| out_valid | output | 1 | Result strobe, one cycle after the request |
| out_vec | output | VLEN | Result vector |
| out_illegal | output | 1 | Reserved size encoding was seen |

## Verification
The bench sweeps all 120 legal immediate codes, including the largest count for each width.

- A full-width shift that wrapped or returned zero would break the sign-fill check.
- An off-by-one in the count subtraction shows up as every lane being off by one bit position.
- A design that tested the wrong predicate bit of a byte group is caught by predicates that set only the upper byte bits of wide lanes; it would shift lanes that must stay untouched.
- The reserved size value is driven with every low-field value. A design that shifted anyway, or cleared the vector, would fail the pass-through check.
- Idle cycles follow each request. A result register that reloaded without a request, or a valid that stretched, would be reported.

// File: rtl/sasr_pkg.sv
package sasr_pkg;

    typedef enum logic [1:0] {
        LW8  = 2'd0,
        LW16 = 2'd1,
        LW32 = 2'd2,
        LW64 = 2'd3
    } lane_sz_e;

    typedef struct packed {
        logic     legal;
        lane_sz_e lane;
        logic [6:0] shamt;
    } shift_ctl_t;

    // Lane width in bits for a lane size code
    function automatic logic [7:0] lane_bits(input lane_sz_e sz);
        return 8'd8 << sz;
    endfunction

    // Highest set bit of the size field picks the lane size
    function automatic lane_sz_e size_to_lane(input logic [3:0] size);
        lane_sz_e r;
        casez (size)
            4'b1???: r = LW64;
            4'b01??: r = LW32;
            4'b001?: r = LW16;
            default: r = LW8;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/sasr_decode.sv
module sasr_decode
    import sasr_pkg::*;
(
    input  logic [3:0] size_f,
    input  logic [2:0] imm3_f,
    output shift_ctl_t ctl
);
    logic [7:0] width_b;
    logic [7:0] twice_w;
    logic [7:0] code;
    logic [7:0] diff;

    always_comb begin
        ctl.legal = |size_f;
        ctl.lane  = size_to_lane(size_f);
        width_b   = lane_bits(ctl.lane);
        twice_w   = width_b << 1;
        code      = {1'b0, size_f, imm3_f};
        diff      = twice_w - code;
        ctl.shamt = diff[6:0];
    end

    always_comb begin
        if (ctl.legal) begin
            AST_SHAMT_RANGE: assert ({1'b0, ctl.shamt} >= 8'd1 && {1'b0, ctl.shamt} <= width_b)
                else $error("shift count outside 1..width"); // R2
        end
    end

endmodule

// File: rtl/sasr_lane.sv
module sasr_lane #(
    parameter int W = 8
) (
    input  logic [W-1:0] op,
    input  logic         act,
    input  logic [6:0]   shamt,
    output logic [W-1:0] res
);
    logic [W-1:0] shifted;

    always_comb begin
        shifted = W'($signed(op) >>> shamt);
        res     = act ? shifted : op;
    end

    always_comb begin
        if (act && (32'(shamt) == W)) begin
            AST_FULL_SHIFT_SIGN: assert (res == {W{op[W-1]}})
                else $error("full-width shift did not sign-fill"); // R3
        end
    end

endmodule

// File: rtl/vec_sra_unit.sv
module vec_sra_unit
    import sasr_pkg::*;
#(
    parameter int VLEN = 256
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  in_valid,
    input  logic [VLEN-1:0]       in_vec,
    input  logic [VLEN/8-1:0]     in_pred,
    input  logic [3:0]            in_size,
    input  logic [2:0]            in_imm3,
    output logic                  out_valid,
    output logic [VLEN-1:0]       out_vec,
    output logic                  out_illegal
);
    localparam int NSIZES = 4;

    shift_ctl_t                  ctl;
    logic [NSIZES-1:0][VLEN-1:0] res_w;
    logic [VLEN-1:0]             res_sel;

    sasr_decode u_dec (
        .size_f (in_size),
        .imm3_f (in_imm3),
        .ctl    (ctl)
    );

    for (genvar k = 0; k < NSIZES; k++) begin : g_w
        localparam int W = 8 << k;
        localparam int N = VLEN / W;
        for (genvar i = 0; i < N; i++) begin : g_l
            sasr_lane #(.W(W)) u_lane (
                .op    (in_vec[i*W +: W]),
                .act   (in_pred[i*W/8]),
                .shamt (ctl.shamt),
                .res   (res_w[k][i*W +: W])
            );
        end
    end

    always_comb begin
        res_sel = ctl.legal ? res_w[ctl.lane] : in_vec;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid   <= 1'b0;
            out_vec     <= '0;
            out_illegal <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_vec     <= res_sel;
                out_illegal <= ~ctl.legal;
            end
        end
    end

    AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid); // R8

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> (!out_valid && $stable(out_vec) && $stable(out_illegal))); // R9

    AST_RESERVED_PASS: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_size == 4'd0) |=> (out_illegal && out_vec == $past(in_vec))); // R7

    AST_LEGAL_NO_FLAG: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_size != 4'd0) |=> !out_illegal); // R7

endmodule

// File: tb/vec_sra_unit_bench.sv
`timescale 1ns/1ps
module vec_sra_unit_bench;
    localparam int VLEN = 256;
    localparam int PW   = VLEN / 8;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            in_valid = 1'b0;
    logic [VLEN-1:0] in_vec = '0;
    logic [PW-1:0]   in_pred = '0;
    logic [3:0]      in_size = '0;
    logic [2:0]      in_imm3 = '0;
    logic            out_valid;
    logic [VLEN-1:0] out_vec;
    logic            out_illegal;

    int n_tests = 0;
    int n_fail  = 0;
    logic [VLEN-1:0] last_vec;
    logic            last_ill;

    always #2.5 clk = ~clk;

    vec_sra_unit #(.VLEN(VLEN)) u_vec_sra_unit (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_vec(in_vec),
        .in_pred(in_pred), .in_size(in_size), .in_imm3(in_imm3),
        .out_valid(out_valid), .out_vec(out_vec), .out_illegal(out_illegal)
    );

    function automatic int width_of(input logic [3:0] s);
        if (s[3]) return 64;
        if (s[2]) return 32;
        if (s[1]) return 16;
        return 8;
    endfunction

    // Behavioural model, one lane and one bit at a time
    function automatic logic [VLEN-1:0] model(input logic [VLEN-1:0] v,
            input logic [PW-1:0] p, input logic [3:0] s, input logic [2:0] i3);
        logic [VLEN-1:0] r;
        int w, sh, base;
        r = v;
        if (s == 4'd0) return r;
        w  = width_of(s);
        sh = 2 * w - int'({s, i3});
        for (int e = 0; e < VLEN / w; e++) begin
            base = e * w;
            if (p[base / 8]) begin
                for (int b = 0; b < w; b++)
                    r[base + b] = (b + sh < w) ? v[base + b + sh] : v[base + w - 1];
            end
        end
        return r;
    endfunction

    function automatic logic [VLEN-1:0] rvec();
        logic [VLEN-1:0] r;
        for (int k = 0; k < VLEN / 32; k++) r[k*32 +: 32] = $urandom;
        return r;
    endfunction

    task automatic chk(input string req, input logic [VLEN-1:0] act, input logic [VLEN-1:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Drive one request, check result, then one idle cycle check
    task automatic run(input string req, input logic [VLEN-1:0] v, input logic [PW-1:0] p,
                       input logic [3:0] s, input logic [2:0] i3);
        logic [VLEN-1:0] e;
        e = model(v, p, s, i3);
        @(negedge clk);
        in_vec = v; in_pred = p; in_size = s; in_imm3 = i3; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        in_vec = rvec(); in_size = 4'($urandom); in_pred = PW'($urandom);
        chk({req, " R8 valid"}, VLEN'(out_valid), VLEN'(1));
        chk(req, out_vec, e);
        chk({req, " R7 flag"}, VLEN'(out_illegal), VLEN'(s == 4'd0));
        last_vec = out_vec; last_ill = out_illegal;
        @(negedge clk);
        chk("R9 idle valid", VLEN'(out_valid), VLEN'(0));
        chk("R9 idle hold", out_vec, last_vec);
        chk("R9 idle flag", VLEN'(out_illegal), VLEN'(last_ill));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [PW-1:0] hp;
        void'($urandom(32'd20240611));
        repeat (4) @(posedge clk);
        @(negedge clk);
        chk("R8 reset valid", VLEN'(out_valid), VLEN'(0));
        rst = 1'b0;

        // R3 maximum shift, one per width, all lanes active
        run("R3 w8 max",  rvec(), '1, 4'b0001, 3'd0);
        run("R3 w16 max", rvec(), '1, 4'b0010, 3'd0);
        run("R3 w32 max", rvec(), '1, 4'b0100, 3'd0);
        run("R3 w64 max", rvec(), '1, 4'b1000, 3'd0);
        // R4 shift by one on negative and positive patterns
        run("R4 w8 by1 neg", {VLEN/8{8'h81}}, '1, 4'b0001, 3'd7);
        run("R4 w64 by1 pos", {VLEN/64{64'h7000_0000_0000_0001}}, '1, 4'b1111, 3'd7);
        // R5 no active lanes
        run("R5 all inactive", rvec(), '0, 4'b0011, 3'd2);
        // R6 only upper byte bits of 64-bit lanes set: no lane active
        hp = '1;
        for (int i = 0; i < PW; i += 8) hp[i] = 1'b0;
        run("R6 upper bits ignored", rvec(), hp, 4'b1010, 3'd3);
        // R6 only lowest byte bits set: every 32-bit lane active
        hp = '0;
        for (int i = 0; i < PW; i += 4) hp[i] = 1'b1;
        run("R6 low bits active", rvec(), hp, 4'b0101, 3'd1);
        // R7 reserved size with every low field
        for (int k = 0; k < 8; k++) run("R7 reserved", rvec(), PW'($urandom), 4'd0, 3'(k));
        // R1 R2 every legal code
        for (int c = 8; c < 128; c++)
            run("R1 R2 sweep", rvec(), PW'($urandom), 4'(c >> 3), 3'(c));
        // Random mix
        for (int n = 0; n < 300; n++)
            run("R4 R5 random", rvec(), PW'($urandom), 4'($urandom), 3'($urandom));

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule